// File: doc/BRIEF.md
# Radix-4 Digit-Reverse Reorder Buffer

This block sits behind a 256-point transform whose results leave in radix-4 digit-reversed order. It accepts one complex sample per clock, made of a 32-bit real word and a 32-bit imaginary word that are never interpreted. For each sample it works out which natural-order bin the sample belongs to and writes it there. The stream then leaves the block in ascending bin order, with its own valid, start and end markers.

The arrival position of a sample is an 8-bit count made of four base-4 digits of two bits each. The natural bin is found by reversing the order of those digits, with the two bits inside each digit kept as they are. This is not a plain bit reversal.

Two banks alternate roles. One collects the frame that is arriving while the other is streamed out. The banks swap on every completed frame, so frames can follow each other with no idle cycle at the input or at the output. An input start marker aligns the position counter to the frame. If a start marker arrives in the middle of a frame, the counter restarts and a one-cycle error flag is raised.

Top module: `quad_digit_reorder`

## Requirements
- R1: A sample accepted at arrival position p (0..255) leaves as bin {p[1:0], p[3:2], p[5:4], p[7:6]}. Examples of position to bin: 0→0, 1→64, 4→16, 16→4, 63→252, 64→1, 255→255. Bin 4 therefore comes from position 16, not from position 32.
- R2: The real and imaginary words of every sample reach `out_re` and `out_im` unchanged.
- R3: A sample is taken, and the position advances, only in cycles with `in_valid` high. Idle cycles in the middle of a frame do not alter the frame's output.
- R4: `in_sof` is acted on only together with `in_valid`. It forces the sample to position 0. If the position was not 0, `frame_err` is high for the following cycle. A start marker at position 0 raises no error. A start marker without `in_valid` is ignored.
- R5: Each output frame has 256 consecutive cycles with `out_valid` high, carrying bins 0 to 255 in ascending order. `out_sof` is high on bin 0 only and `out_eof` on bin 255 only.
- R6: If the 256th sample of a frame is taken at clock edge k, then bin 0 is on the outputs after edge k+1, and bin j after edge k+1+j.
- R7: Input frames sent with no gap between them produce output frames with no gap: the cycle after `out_eof` carries `out_sof` of the next frame. A bank is never written while it is being read.
- R8: While `rst_n` is low, `out_valid`, `out_sof`, `out_eof` and `frame_err` are low. The position counter and the bank select are cleared. Release of reset takes effect synchronously to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | First sample of an input frame (meaningful with in_valid) |
| in_re | input | 32 | Real word of the input sample |
| in_im | input | 32 | Imaginary word of the input sample |
| out_valid | output | 1 | Output sample present |
| out_sof | output | 1 | Output bin 0 |
| out_eof | output | 1 | Output bin 255 |
| out_re | output | 32 | Real word of the output bin |
| out_im | output | 32 | Imaginary word of the output bin |
| frame_err | output | 1 | Start marker seen at a nonzero position (one-cycle pulse) |

## Verification
With gapless input, the last sample of one frame is written, and the banks swap, on the same clock edge that emits the final bin of the previous frame. The start of the next readout therefore has to win over the end of the current one. The bench provokes this by sending three frames back to back. It judges the result by requiring that `out_valid` never drops between frames, that every `out_eof` is followed at once by `out_sof`, and that every bin of all three frames carries the words tagged with its own frame number and arrival position.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

  // Width of one base-4 digit of the position index
  localparam int DIGIT_W = 2;

  // Readout sequencer states
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_RUN  = 1'b1
  } rd_state_e;

endpackage

// File: rtl/qdr_rst_sync.sv
module qdr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/qdr_wr_ctrl.sv
module qdr_wr_ctrl
  import qdr_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sof,
  output logic                        wr_en,
  output logic [DIGIT_W*DIGITS-1:0]   wr_addr,
  output logic                        wr_bank,
  output logic                        frame_done,
  output logic                        done_bank,
  output logic                        frame_err
);

  localparam int IDX_W = DIGIT_W * DIGITS;

  // Reverse the order of the base-4 digits, bits inside a digit kept in place
  function automatic logic [IDX_W-1:0] digit_rev(input logic [IDX_W-1:0] p);
    logic [IDX_W-1:0] r;
    for (int i = 0; i < DIGITS; i++) begin
      r[DIGIT_W*(DIGITS-1-i) +: DIGIT_W] = p[DIGIT_W*i +: DIGIT_W];
    end
    return r;
  endfunction

  logic [IDX_W-1:0] pos_q, pos_d, eff_pos;
  logic             bank_q, bank_d;
  logic             err_q, err_d;
  logic             last_pos;

  // Next-state logic
  always_comb begin
    eff_pos    = in_sof ? '0 : pos_q;
    last_pos   = &eff_pos;
    wr_en      = in_valid;
    wr_addr    = digit_rev(eff_pos);
    frame_done = in_valid && last_pos;
    pos_d      = pos_q;
    bank_d     = bank_q;
    if (in_valid) begin
      pos_d = eff_pos + 1'b1;
    end
    if (frame_done) begin
      bank_d = ~bank_q;
    end
    err_d = in_valid && in_sof && (pos_q != '0);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      bank_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      bank_q <= bank_d;
      err_q  <= err_d;
    end
  end

  assign wr_bank   = bank_q;
  assign done_bank = bank_q;
  assign frame_err = err_q;

  AST_POS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos_q)); // R3
  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof |=> pos_q == IDX_W'(1)); // R4
  AST_NO_ERR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof && (pos_q == '0) |=> !frame_err); // R4
  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> wr_bank != $past(wr_bank)); // R7

endmodule

// File: rtl/qdr_bank.sv
module qdr_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/qdr_rd_ctrl.sv
module qdr_rd_ctrl
  import qdr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_bank,
  output logic [IDX_W-1:0] rd_addr,
  output logic             rd_bank,
  output logic             emit,
  output logic             first,
  output logic             last
);

  rd_state_e        state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             bank_q, bank_d;

  // Next-state logic: a new start wins over the end of the current frame
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bank_d  = bank_q;
    if (start) begin
      state_d = RD_RUN;
      cnt_d   = '0;
      bank_d  = start_bank;
    end else if (state_q == RD_RUN) begin
      if (&cnt_q) begin
        state_d = RD_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      cnt_q   <= '0;
      bank_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bank_q  <= bank_d;
    end
  end

  assign emit    = (state_q == RD_RUN);
  assign rd_addr = cnt_q;
  assign rd_bank = bank_q;
  assign first   = (cnt_q == '0);
  assign last    = &cnt_q;

  AST_RUN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    emit && !last && !start |=> emit && (rd_addr == $past(rd_addr) + 1'b1)); // R5
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> emit && first); // R6

endmodule

// File: rtl/quad_digit_reorder.sv
module quad_digit_reorder
  import qdr_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [WORD_W-1:0] in_re,
  input  logic [WORD_W-1:0] in_im,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [WORD_W-1:0] out_re,
  output logic [WORD_W-1:0] out_im,
  output logic              frame_err
);

  localparam int IDX_W  = DIGIT_W * DIGITS;
  localparam int DATA_W = 2 * WORD_W;
  localparam int BANKS  = 2;

  logic              srst_n;
  logic              wr_en, wr_bank, frame_done, done_bank;
  logic [IDX_W-1:0]  wr_addr, rd_addr;
  logic              rd_bank, emit, first, last;
  logic [DATA_W-1:0] bank_rdata [BANKS];

  logic              vld_q, vld_d, sof_q, sof_d, eof_q, eof_d;
  logic [DATA_W-1:0] data_q, data_d;

  qdr_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  qdr_wr_ctrl #(.DIGITS(DIGITS)) u_wr_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_bank    (wr_bank),
    .frame_done (frame_done),
    .done_bank  (done_bank),
    .frame_err  (frame_err)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic SEL = 1'(b);
    qdr_bank #(.ADDR_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .we    (wr_en && (wr_bank == SEL)),
      .waddr (wr_addr),
      .wdata ({in_im, in_re}),
      .raddr (rd_addr),
      .rdata (bank_rdata[b])
    );
  end

  qdr_rd_ctrl #(.IDX_W(IDX_W)) u_rd_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .start      (frame_done),
    .start_bank (done_bank),
    .rd_addr    (rd_addr),
    .rd_bank    (rd_bank),
    .emit       (emit),
    .first      (first),
    .last       (last)
  );

  // Output stage next state, data held when no bin is emitted
  always_comb begin
    vld_d  = emit;
    sof_d  = emit && first;
    eof_d  = emit && last;
    data_d = emit ? bank_rdata[rd_bank] : data_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q  <= 1'b0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      sof_q  <= sof_d;
      eof_q  <= eof_d;
      data_q <= data_d;
    end
  end

  assign out_valid = vld_q;
  assign out_sof   = sof_q;
  assign out_eof   = eof_q;
  assign out_re    = data_q[WORD_W-1:0];
  assign out_im    = data_q[DATA_W-1:WORD_W];

  AST_MARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!srst_n)
    (out_sof || out_eof) |-> out_valid); // R5
  AST_NO_GAP_IN_FRAME: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid && !out_eof |=> out_valid && !out_sof); // R5
  AST_EOF_THEN_SOF_OR_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    out_eof |=> !out_valid || out_sof); // R7
  AST_BANK_NOT_SHARED: assert property (@(posedge clk) disable iff (!srst_n)
    emit && wr_en |-> wr_bank != rd_bank); // R7

endmodule

// File: tb/quad_digit_reorder_tb.sv
module quad_digit_reorder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NBINS      = 256;
  localparam int WATCHDOG   = 150000;

  // Arrival position (high byte) to natural bin (low byte), from R1
  localparam logic [15:0] MAP_VEC [8] = '{
    {8'd0,   8'd0},
    {8'd1,   8'd64},
    {8'd4,   8'd16},
    {8'd16,  8'd4},
    {8'd63,  8'd252},
    {8'd64,  8'd1},
    {8'd255, 8'd255},
    {8'd32,  8'd8}
  };

  logic        clk, rst_n, in_valid, in_sof;
  logic [31:0] in_re, in_im;
  logic        out_valid, out_sof, out_eof, frame_err;
  logic [31:0] out_re, out_im;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  quad_digit_reorder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_re    (out_re),
    .out_im    (out_im),
    .frame_err (frame_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int nat_bin(int p);
    int r = 0;
    for (int i = 0; i < 4; i++) r = r * 4 + ((p >> (2 * i)) % 4);
    return r;
  endfunction

  function automatic logic [31:0] mk_re(int fid, int pos);
    return {8'hC3, 8'(fid), 8'h5A, 8'(pos)};
  endfunction

  function automatic logic [31:0] mk_im(int fid, int pos);
    return {8'(pos), 8'h3C, 8'(fid), 8'h96};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Drive one frame; gapped frames insert idle cycles, one with a stray start marker
  task automatic send_frame(input int fid, input bit gapped);
    for (int p = 0; p < NBINS; p++) begin
      if (gapped && (p % 2 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = (p == 101);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (p == 0);
      in_re    = mk_re(fid, p);
      in_im    = mk_im(fid, p);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  // Output monitor
  int          exp_bin = 0;
  int          out_frames = 0;
  int          bad = 0;
  int          gap_count = 0;
  int          bb_count = 0;
  int          err_count = 0;
  bit          open_frame = 0;
  bit          prev_eof = 0;
  int          frame_bad [8];
  logic [31:0] cap_re [NBINS];

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_err) err_count++;
      if (out_valid) begin
        int fid;
        int pos;
        fid = out_frames + 1;
        pos = nat_bin(exp_bin);
        if (out_sof != (exp_bin == 0))     bad++;
        if (out_eof != (exp_bin == NBINS-1)) bad++;
        if (out_re != mk_re(fid, pos) || out_im != mk_im(fid, pos)) bad++;
        if (prev_eof && out_sof) bb_count++;
        cap_re[exp_bin] = out_re;
        open_frame = 1'b1;
        if (exp_bin == NBINS-1) begin
          // R1 R2 R5: whole frame in natural order with intact words and markers
          chk(bad == 0, "R1 R2 R5 frame content", 64'(bad), 64'd0);
          if (fid < 8) frame_bad[fid] = bad;
          bad = 0;
          exp_bin = 0;
          out_frames++;
          open_frame = 1'b0;
        end else begin
          exp_bin++;
        end
      end else if (open_frame) begin
        gap_count++;
      end
      prev_eof = out_valid && out_eof;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      chk(1'b0, "watchdog", 64'(cyc), 64'd0);
      finish_run();
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_re    = '0;
    in_im    = '0;
    for (int i = 0; i < 8; i++) frame_bad[i] = -1;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8 out_valid in reset", 64'(out_valid), 64'd0);
    chk(out_sof == 1'b0 && out_eof == 1'b0, "R8 markers in reset", {62'd0, out_sof, out_eof}, 64'd0);
    chk(frame_err == 1'b0, "R8 frame_err in reset", 64'(frame_err), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R8 idle after release", 64'(out_valid), 64'd0);

    // R6: latency from the last accepted sample
    send_frame(1, 1'b0);
    go_idle();
    chk(out_valid == 1'b0, "R6 no output one edge after completion", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk(out_valid && out_sof, "R6 bin 0 after second edge", {62'd0, out_valid, out_sof}, 64'd3);
    repeat (300) @(negedge clk);

    // R7: three frames back to back
    send_frame(2, 1'b0);
    send_frame(3, 1'b0);
    send_frame(4, 1'b0);
    go_idle();
    repeat (300) @(negedge clk);

    // R3 and R4: gapped frame with a start marker on an idle cycle
    send_frame(5, 1'b1);
    go_idle();
    repeat (300) @(negedge clk);
    chk(frame_bad[5] == 0, "R3 gapped frame intact", 64'(frame_bad[5]), 64'd0);
    chk(err_count == 0, "R4 stray start without valid ignored", 64'(err_count), 64'd0);

    // R4: aborted partial frame, then a restart
    for (int p = 0; p < 10; p++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (p == 0);
      in_re    = mk_re(8'hEE, p);
      in_im    = mk_im(8'hEE, p);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_sof   = 1'b1;
    in_re    = mk_re(6, 0);
    in_im    = mk_im(6, 0);
    @(negedge clk);
    chk(frame_err == 1'b1, "R4 error pulse on mid-frame start", 64'(frame_err), 64'd1);
    for (int p = 1; p < NBINS; p++) begin
      if (p > 1) @(negedge clk);
      in_valid = 1'b1;
      in_sof   = 1'b0;
      in_re    = mk_re(6, p);
      in_im    = mk_im(6, p);
      if (p == 1) begin
        @(negedge clk);
        chk(frame_err == 1'b0, "R4 error is one cycle", 64'(frame_err), 64'd0);
        in_re = mk_re(6, 2);
        in_im = mk_im(6, 2);
        p = 2;
      end
    end
    go_idle();
    repeat (300) @(negedge clk);
    chk(frame_bad[6] == 0, "R4 restarted frame intact", 64'(frame_bad[6]), 64'd0);

    // R1: mapping table against the last captured frame
    for (int v = 0; v < 8; v++) begin
      int pos;
      int bin;
      pos = int'(MAP_VEC[v][15:8]);
      bin = int'(MAP_VEC[v][7:0]);
      chk(cap_re[bin] == mk_re(6, pos), "R1 mapping vector", 64'(cap_re[bin]), 64'(mk_re(6, pos)));
    end

    chk(out_frames == 6, "R5 frame count", 64'(out_frames), 64'd6);
    chk(gap_count == 0, "R7 no gap inside frames", 64'(gap_count), 64'd0);
    chk(bb_count >= 2, "R7 eof followed by sof", 64'(bb_count), 64'd2);
    chk(err_count == 1, "R4 total error pulses", 64'(err_count), 64'd1);

    finish_run();
  end

endmodule